// File: doc/BRIEF.md
# Prioritized External Interrupt Request Controller

This block collects four external interrupt request pins and presents one prioritized request to a CPU core. Each pin has its own sense mode and its own 4-bit priority. The pin inputs are synchronized, and edges are detected on the synchronized samples. An edge-sensed event is held in a per-pin latch until it is served or cleared by software. The highest-priority pending pin is raised as a request only when its priority is strictly above the CPU's current 4-bit mask level.

When the CPU acknowledges, the block records the winning level and starts a short handshake. One cycle is a vector-fetch cycle. In external-vector mode this cycle drives the accepted level on an output bus, pulses a fetch strobe and samples an 8-bit vector byte. Bit 7 of that byte is forced to zero. In internal-vector mode the block computes the vector itself. A one-cycle valid pulse then presents the vector and the new CPU mask, which equals the accepted level.

Software programs the block through a small write-only register port:
- address 0 holds the controls,
- address 1 holds the sense fields,
- address 2 holds the priority fields,
- address 3 is a write-1-to-clear port for the edge latches.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, irq_req, vec_fetch and vec_valid are 0, and acc_level, irq_level, vec_num and new_mask are 0. After reset, both control bits are 0, every sense field is 00, every priority is 0, and the synchronizer stages hold 1.
- R2: Address 1 holds the sense field of pin i in bits [2i+1:2i]. The codes are 00 = active-low level, 01 = rising edge, 10 = falling edge and 11 = both edges. Each pin passes through two synchronizer flops. Edges are found by comparing the second flop with the previous value of the second flop.
- R3: Address 0 bit 0 is the request enable. While it is 0, irq_req stays 0, but the edge latches keep capturing.
- R4: Address 2 holds the priority of pin i in bits [4i+3:4i]. A pending pin is eligible only if its priority is strictly greater than cpu_mask, so a priority of 0 never raises a request.
- R5: irq_level is the highest priority among the eligible pins. When pins tie, the lowest-numbered pin wins. irq_level is 0 whenever irq_req is 0.
- R6: Address 0 bit 1 selects external-vector mode. An acknowledge (cpu_ack while irq_req is 1) is followed by one fetch cycle. In external-vector mode, vec_fetch is high for exactly that cycle, and acc_level carries the accepted level during it (and is 0 otherwise). vec_data is sampled at the end of the fetch cycle, with bit 7 forced to 0.
- R7: In internal-vector mode, vec_fetch stays 0, acc_level stays 0, and the vector is 64 plus the accepted level divided by 2 (rounded down).
- R8: vec_valid pulses for one cycle, in the cycle after the fetch cycle. While it is high, vec_num and new_mask hold the vector and the accepted level. irq_req is 0 from the acknowledge until vec_valid falls. cpu_ack has no effect while irq_req is 0.
- R9: An edge latch is cleared by the acknowledge of its own pin, or by writing 1 to bit i at address 3. An edge detected in the same cycle takes precedence over the clear. Level-sensed pins are not latched, so releasing such a pin withdraws its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 4 | External request pins |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cpu_mask | input | 4 | Current CPU interrupt mask level |
| irq_req | output | 1 | Prioritized interrupt request |
| irq_level | output | 4 | Level of the requesting pin |
| cpu_ack | input | 1 | CPU acknowledge |
| vec_fetch | output | 1 | External vector fetch strobe |
| acc_level | output | 4 | Accepted level during the fetch cycle |
| vec_data | input | 8 | External vector byte |
| vec_valid | output | 1 | One-cycle vector valid pulse |
| vec_num | output | 8 | Vector number |
| new_mask | output | 4 | Mask value for the CPU to load |

## Verification
A stale or missing edge latch shows up on irq_req and irq_level in the same cycle the latch is wrong. It shows up three edges after a pin event that should have set it, or one edge after a clear that was ignored. A wrong handshake state shows up at once: the fetch strobe or the valid pulse arrives in the wrong cycle, lasts the wrong length, or the request is not masked during service. A wrong accepted level shows up on acc_level in the fetch cycle and on new_mask one cycle later. The bench compares every output on every clock against a behavioural model, so a divergence is reported in the first cycle it is visible.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NPINS = 4,
  parameter int LW = 4,
  parameter int VW = 8,
  localparam int DW = NPINS * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_pin,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [LW-1:0]    cpu_mask,
  output logic             irq_req,
  output logic [LW-1:0]    irq_level,
  input  logic             cpu_ack,
  output logic             vec_fetch,
  output logic [LW-1:0]    acc_level,
  input  logic [VW-1:0]    vec_data,
  output logic             vec_valid,
  output logic [VW-1:0]    vec_num,
  output logic [LW-1:0]    new_mask
);
  localparam int PIW = (NPINS > 1) ? $clog2(NPINS) : 1;

  typedef enum logic [1:0] {IDLE, FETCH, DONE} st_t;

  st_t                st;
  logic               pin_en, xvec_en;
  logic [2*NPINS-1:0] sense;
  logic [DW-1:0]      prio;
  logic [NPINS-1:0]   sy1, sy2, sy3, hold, hit, pend, elig, clr;
  logic [LW-1:0]      lvl, best_lvl;
  logic [PIW-1:0]     best_pin;
  logic               best_ok, take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_en  <= 1'b0;
      xvec_en <= 1'b0;
      sense   <= '0;
      prio    <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin
          pin_en  <= cfg_wdata[0];
          xvec_en <= cfg_wdata[1];
        end
        2'd1: sense <= cfg_wdata[2*NPINS-1:0];
        2'd2: prio  <= cfg_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sy3, sy2, sy1} <= '1;
    else        {sy3, sy2, sy1} <= {sy2, sy1, irq_pin};

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] md;
    logic       rise, fall;
    assign md      = sense[2*i +: 2];
    assign rise    = sy2[i] & ~sy3[i];
    assign fall    = ~sy2[i] & sy3[i];
    assign hit[i]  = (md == 2'b01 & rise) | (md == 2'b10 & fall) | (md == 2'b11 & (rise | fall));
    assign pend[i] = (md == 2'b00) ? ~sy2[i] : hold[i];
    assign elig[i] = pend[i] && (prio[i*LW +: LW] > cpu_mask);
  end

  always_comb begin
    best_ok  = 1'b0;
    best_lvl = '0;
    best_pin = '0;
    for (int i = 0; i < NPINS; i++)
      if (elig[i] && (!best_ok || prio[i*LW +: LW] > best_lvl)) begin
        best_ok  = 1'b1;
        best_lvl = prio[i*LW +: LW];
        best_pin = PIW'(i);
      end
  end

  assign irq_req   = pin_en & best_ok & (st == IDLE);
  assign irq_level = irq_req ? best_lvl : '0;
  assign take      = irq_req & cpu_ack;

  assign clr = ((cfg_we && cfg_addr == 2'd3) ? cfg_wdata[NPINS-1:0] : '0)
             | (take ? (NPINS'(1) << best_pin) : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold <= '0;
    else        hold <= (hold & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= IDLE;
      lvl      <= '0;
      vec_num  <= '0;
      new_mask <= '0;
    end else begin
      case (st)
        IDLE: if (take) begin
          lvl <= best_lvl;
          st  <= FETCH;
        end
        FETCH: begin
          vec_num  <= xvec_en ? {1'b0, vec_data[VW-2:0]} : VW'(64) + VW'(lvl >> 1);
          new_mask <= lvl;
          st       <= DONE;
        end
        default: st <= IDLE;
      endcase
    end

  assign vec_fetch = (st == FETCH) & xvec_en;
  assign acc_level = vec_fetch ? lvl : '0;
  assign vec_valid = (st == DONE);
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int LW = 4,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pin_en,
  input logic          irq_req,
  input logic [LW-1:0] irq_level,
  input logic [LW-1:0] cpu_mask,
  input logic          vec_fetch,
  input logic [LW-1:0] acc_level,
  input logic          vec_valid,
  input logic [VW-1:0] vec_num,
  input logic [LW-1:0] new_mask
);
  assert_req_off_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> !irq_req);

  assert_level_above_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_level > cpu_mask);

  assert_fetch_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |=> !vec_fetch);

  assert_fetch_level_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> acc_level != '0);

  assert_idle_level_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_fetch |-> acc_level == '0);

  assert_ext_vector_top_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |=> vec_valid && !vec_num[VW-1]);

  assert_mask_follows_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |=> new_mask == $past(acc_level));

  assert_valid_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  assert_no_req_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid || vec_fetch) |-> !irq_req);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.LW(LW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .irq_req(irq_req),
  .irq_level(irq_level), .cpu_mask(cpu_mask), .vec_fetch(vec_fetch),
  .acc_level(acc_level), .vec_valid(vec_valid), .vec_num(vec_num),
  .new_mask(new_mask)
);

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  localparam int NP = 4;

  logic       clk = 0, rst_n = 0;
  logic [3:0] irq_pin = 4'hF;
  logic       cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [3:0] cpu_mask = 0;
  logic       cpu_ack = 0;
  logic [7:0] vec_data = 0;
  logic       irq_req, vec_fetch, vec_valid;
  logic [3:0] irq_level, acc_level, new_mask;
  logic [7:0] vec_num;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cpu_mask(cpu_mask),
    .irq_req(irq_req), .irq_level(irq_level), .cpu_ack(cpu_ack),
    .vec_fetch(vec_fetch), .acc_level(acc_level), .vec_data(vec_data),
    .vec_valid(vec_valid), .vec_num(vec_num), .new_mask(new_mask)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // behavioural model
  int ms1[NP], ms2[NP], ms3[NP], mhold[NP], msense[NP], mpri[NP];
  int men, mxv, mst, mlvl, mvnum, mnmask;
  int e_ok, e_lvl, e_pin;

  task automatic m_arb();
    e_ok = 0; e_lvl = 0; e_pin = 0;
    for (int i = 0; i < NP; i++) begin
      int pend;
      pend = (msense[i] == 0) ? (ms2[i] == 0) : mhold[i];
      if (pend != 0 && mpri[i] > int'(cpu_mask) && (e_ok == 0 || mpri[i] > e_lvl)) begin
        e_ok = 1; e_lvl = mpri[i]; e_pin = i;
      end
    end
    if (!(e_ok != 0 && men != 0 && mst == 0)) begin e_ok = 0; e_lvl = 0; end
  endtask

  always @(posedge clk) begin : model
    int tk;
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        ms1[i] = 1; ms2[i] = 1; ms3[i] = 1; mhold[i] = 0; msense[i] = 0; mpri[i] = 0;
      end
      men = 0; mxv = 0; mst = 0; mlvl = 0; mvnum = 0; mnmask = 0;
    end else begin
      m_arb();
      tk = (e_ok != 0 && cpu_ack) ? 1 : 0;
      for (int i = 0; i < NP; i++) begin
        int r, f, h, c;
        r = (ms2[i] == 1 && ms3[i] == 0) ? 1 : 0;
        f = (ms2[i] == 0 && ms3[i] == 1) ? 1 : 0;
        h = ((msense[i] == 1 && r != 0) || (msense[i] == 2 && f != 0) ||
             (msense[i] == 3 && (r != 0 || f != 0))) ? 1 : 0;
        c = ((cfg_we && cfg_addr == 3 && cfg_wdata[i]) || (tk != 0 && e_pin == i)) ? 1 : 0;
        if (h != 0) mhold[i] = 1; else if (c != 0) mhold[i] = 0;
        ms3[i] = ms2[i]; ms2[i] = ms1[i]; ms1[i] = irq_pin[i];
      end
      if (mst == 0) begin
        if (tk != 0) begin mlvl = e_lvl; mst = 1; end
      end else if (mst == 1) begin
        mvnum  = (mxv != 0) ? (int'(vec_data) % 128) : 64 + mlvl / 2;
        mnmask = mlvl;
        mst = 2;
      end else mst = 0;
      if (cfg_we) begin
        if (cfg_addr == 0) begin men = cfg_wdata[0]; mxv = cfg_wdata[1]; end
        if (cfg_addr == 1) for (int i = 0; i < NP; i++) msense[i] = (cfg_wdata >> (2*i)) & 3;
        if (cfg_addr == 2) for (int i = 0; i < NP; i++) mpri[i] = (cfg_wdata >> (4*i)) & 15;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int ef;
      m_arb();
      ef = (mst == 1 && mxv != 0) ? 1 : 0;
      chk("R4 irq_req", irq_req, e_ok);
      chk("R5 irq_level", irq_level, e_lvl);
      chk("R6 vec_fetch", vec_fetch, ef);
      chk("R6 acc_level", acc_level, ef != 0 ? mlvl : 0);
      chk("R8 vec_valid", vec_valid, mst == 2 ? 1 : 0);
      chk("R7 vec_num", vec_num, mvnum);
      chk("R8 new_mask", new_mask, mnmask);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept(output int vn, output int nm);
    int n;
    n = 0;
    @(negedge clk); #2;
    while (!irq_req && n < 30) begin @(negedge clk); #2; n++; end
    cpu_ack = 1;
    @(negedge clk);
    cpu_ack = 0;
    n = 0; #2;
    while (!vec_valid && n < 10) begin @(negedge clk); #2; n++; end
    vn = vec_num; nm = new_mask;
  endtask

  initial begin
    #(200000 * 5);
    chk("watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vn, nm;
    wait_n(3);
    #1;
    // R1 reset state
    chk("R1 irq_req", irq_req, 0);
    chk("R1 vec_fetch", vec_fetch, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 vec_num", vec_num, 0);
    chk("R1 new_mask", new_mask, 0);
    rst_n = 1;
    wait_n(2);

    // R5 tie among level pins, R6 external vector with bit 7 forced
    wr(0, 3); wr(1, 0); wr(2, 16'h0553);
    cpu_mask = 2; vec_data = 8'hC5;
    irq_pin = 4'b0000;
    accept(vn, nm);
    chk("R6 ext vector", vn, 8'h45);
    chk("R5 tie winner level", nm, 5);
    cpu_mask = 4'(nm);
    wait_n(2); #2;
    chk("R4 equal level blocked", irq_req, 0);
    irq_pin = 4'hF; cpu_mask = 0;
    wait_n(4);

    // R7 internal vector
    wr(0, 1);
    irq_pin = 4'b1110;
    accept(vn, nm);
    chk("R7 internal vector", vn, 65);
    chk("R7 new mask", nm, 3);
    irq_pin = 4'hF;
    wait_n(4); #2;
    chk("R9 level release drops req", irq_req, 0);

    // R2 edge modes: pin0 rising, pin1 falling, pin2 both
    wr(0, 3); wr(1, 16'h39); wr(2, 16'h0496);
    vec_data = 8'h12;
    irq_pin = 4'b1100;
    wait_n(4);
    irq_pin = 4'hF;
    wait_n(4);
    accept(vn, nm);
    chk("R2 falling latch served", nm, 9);
    chk("R6 vector byte", vn, 8'h12);
    wait_n(1); #2;
    chk("R9 rising latch persists", irq_level, 6);
    wr(3, 1);
    wait_n(1); #2;
    chk("R9 software clear", irq_req, 0);
    irq_pin = 4'b1011;
    wait_n(4);
    accept(vn, nm);
    chk("R2 both-edge fall", nm, 4);
    irq_pin = 4'hF;
    wait_n(4);
    wr(0, 2);
    wait_n(1); #2;
    chk("R3 disabled", irq_req, 0);
    wr(0, 3);
    wait_n(1); #2;
    chk("R3 latch kept while disabled", irq_level, 4);
    wr(3, 4);
    wait_n(2);

    // R8 acknowledge without request ignored
    cpu_mask = 15;
    @(negedge clk); cpu_ack = 1;
    @(negedge clk); cpu_ack = 0;
    wait_n(3); #2;
    chk("R8 stray ack", vec_valid, 0);
    wait_n(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule